// File: doc/BRIEF.md
# Paged Address Translation Table

This block turns a local memory-mapped bus address into a wide PCI Express address. It does this by swapping the upper address bits for a value held in a small table that software writes at run time. The low offset bits of the incoming address pass through unchanged. The page-index bits just above the offset pick one table row. Any bits above the page index are used by the system interconnect for slave selection, and the block ignores them.

Each row holds the base address of one remote segment. Every segment has the same size. Each row also holds a 2-bit space code that makes the result either a 32-bit address or a full 64-bit address. The table has 2^IDX_W rows, up to 512. Software writes and reads the rows through a separate word-addressed 32-bit configuration port. A translation takes one clock cycle.

Top module: `page_xlat`

## Requirements
- R1: After reset, every table row is zero. Every configuration read returns 0, out_valid is low, and a translation yields the offset bits alone, with out_is64 low.
- R2: When in_valid is high in a cycle, out_valid is high in the next cycle with that address's result. Otherwise out_valid is low in the next cycle.
- R3: out_addr[OFFS_W-1:0] equals in_addr[OFFS_W-1:0] of the translated request (OFFS_W = 20 by default, for a 1 MiB page).
- R4: in_addr[OFFS_W+IDX_W-1:OFFS_W] selects the table row (bits [23:20] by default). Bits above the index have no effect on the result.
- R5: For a row with space code 2'b01, out_addr[OUT_W-1:OFFS_W] equals the row's base bits [63:OFFS_W], and out_is64 is high.
- R6: For space code 2'b00, and for the reserved codes 2'b10 and 2'b11, out_addr[63:32] is zero and out_is64 is low. Bits [31:OFFS_W] still come from the row's base.
- R7: Configuration word 2i is the low word of row i. Bits [31:OFFS_W] hold base bits [31:OFFS_W], bits [1:0] hold the space code, and bits [OFFS_W-1:2] are dropped on write and read back as zero. Word 2i+1 holds base bits [63:32].
- R8: cfg_rdata shows the addressed word in the cycle after cfg_rd is high. It holds its value while cfg_rd is low, including across writes.
- R9: If a configuration write and a translation use the same row in the same cycle, the translation uses the row's old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Translation request strobe |
| in_addr | input | ADDR_W | Local bus address to translate |
| out_valid | output | 1 | Translated address is valid |
| out_addr | output | OUT_W | Translated PCI Express address |
| out_is64 | output | 1 | Result uses 64-bit addressing |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | IDX_W+1 | Configuration word address (row, then half) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, registered |

## Verification
A corrupted row appears in the very next translation that indexes it. The symptom is a wrong upper field, a wrong out_is64, or nonzero upper bits on a narrow result. The same fault is also visible one cycle after a configuration read of that row. A slip in the pipeline register shows up in the cycle after the request: a mismatched offset, or a result whose timing is off by a cycle. A write-ordering fault shows only on the collision cycle. It is caught when that translation returns the row's new contents instead of the old ones.

// File: rtl/page_xlat_pkg.sv
package page_xlat_pkg;
    // Space code that selects full-width addressing; every other code is narrow.
    localparam logic [1:0] SP_WIDE = 2'b01;

    function automatic logic sp_is_wide(logic [1:0] sp);
        return sp == SP_WIDE;
    endfunction
endpackage

// File: rtl/page_xlat_table.sv
module page_xlat_table #(
    parameter int OFFS_W = 20,
    parameter int IDX_W  = 4,
    parameter int OUT_W  = 64,
    localparam int DEPTH = 1 << IDX_W,
    localparam int LO_W  = 32 - OFFS_W,
    localparam int HI_W  = OUT_W - 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [IDX_W:0]    cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LO_W-1:0]   rd_lo,
    output logic [HI_W-1:0]   rd_hi,
    output logic [1:0]        rd_sp
);
    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] hi;
        logic [1:0]      sp;
    } row_t;

    typedef struct packed {
        row_t [DEPTH-1:0] rows;
        logic [31:0]      rdata;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    logic [IDX_W-1:0] cfg_row;
    logic             cfg_high;
    logic             unused_wd;

    assign cfg_row   = cfg_addr[IDX_W:1];
    assign cfg_high  = cfg_addr[0];
    assign unused_wd = ^cfg_wdata[OFFS_W-1:2];

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            if (cfg_high) begin
                st_d.rows[cfg_row].hi = cfg_wdata[HI_W-1:0];
            end else begin
                st_d.rows[cfg_row].lo = cfg_wdata[31:OFFS_W];
                st_d.rows[cfg_row].sp = cfg_wdata[1:0];
            end
        end
        if (cfg_rd) begin
            if (cfg_high) begin
                st_d.rdata = 32'(st_q.rows[cfg_row].hi);
            end else begin
                st_d.rdata = {st_q.rows[cfg_row].lo, {(OFFS_W-2){1'b0}},
                              st_q.rows[cfg_row].sp};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cfg_rdata = st_q.rdata;
    assign rd_lo     = st_q.rows[rd_idx].lo;
    assign rd_hi     = st_q.rows[rd_idx].hi;
    assign rd_sp     = st_q.rows[rd_idx].sp;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd |=> $stable(cfg_rdata)); // R8
endmodule

// File: rtl/page_xlat_pipe.sv
module page_xlat_pipe
    import page_xlat_pkg::*;
#(
    parameter int OFFS_W = 20,
    parameter int OUT_W  = 64,
    localparam int LO_W  = 32 - OFFS_W,
    localparam int HI_W  = OUT_W - 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OFFS_W-1:0] in_off,
    input  logic [LO_W-1:0]   row_lo,
    input  logic [HI_W-1:0]   row_hi,
    input  logic [1:0]        row_sp,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_addr,
    output logic              out_is64
);
    typedef struct packed {
        logic              vld;
        logic [OFFS_W-1:0] off;
        logic [LO_W-1:0]   lo;
        logic [HI_W-1:0]   hi;
        logic [1:0]        sp;
    } pipe_state_t;

    pipe_state_t st_d, st_q;
    logic        wide;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.off = in_off;
            st_d.lo  = row_lo;
            st_d.hi  = row_hi;
            st_d.sp  = row_sp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wide      = sp_is_wide(st_q.sp);
    assign out_valid = st_q.vld;
    assign out_is64  = wide;
    assign out_addr  = {(wide ? st_q.hi : {HI_W{1'b0}}), st_q.lo, st_q.off};

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_addr[OFFS_W-1:0] == $past(in_off)); // R3
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is64) |-> out_addr[OUT_W-1:32] == '0); // R6
endmodule

// File: rtl/page_xlat.sv
module page_xlat #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 20,
    parameter int IDX_W  = 4,
    parameter int OUT_W  = 64,
    localparam int TOP_B = OFFS_W + IDX_W,
    localparam int LO_W  = 32 - OFFS_W,
    localparam int HI_W  = OUT_W - 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_addr,
    output logic              out_is64,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [IDX_W:0]    cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata
);
    logic [LO_W-1:0] row_lo;
    logic [HI_W-1:0] row_hi;
    logic [1:0]      row_sp;
    logic            unused_sel;

    // Bits above the page index belong to interconnect slave selection.
    assign unused_sel = ^in_addr[ADDR_W-1:TOP_B];

    page_xlat_table #(.OFFS_W(OFFS_W), .IDX_W(IDX_W), .OUT_W(OUT_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .rd_idx    (in_addr[TOP_B-1:OFFS_W]),
        .rd_lo     (row_lo),
        .rd_hi     (row_hi),
        .rd_sp     (row_sp)
    );

    page_xlat_pipe #(.OFFS_W(OFFS_W), .OUT_W(OUT_W)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_off    (in_addr[OFFS_W-1:0]),
        .row_lo    (row_lo),
        .row_hi    (row_hi),
        .row_sp    (row_sp),
        .out_valid (out_valid),
        .out_addr  (out_addr),
        .out_is64  (out_is64)
    );

    AST_WIDE_UPPER_SRC: assert property (@(posedge clk) disable iff (rst)
        (in_valid && row_sp == 2'b01) |=> (out_is64 && out_addr[OUT_W-1:32] == $past(row_hi))); // R5
endmodule

// File: tb/page_xlat_tb.sv
`timescale 1ns/1ps
module page_xlat_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic [63:0] out_addr;
    logic        out_is64;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    int unsigned total = 0;
    int unsigned bad = 0;
    int unsigned cyc = 0;

    logic [31:0] m_lo [16];
    logic [31:0] m_hi [16];
    logic [96:0] sbq [$];
    string       tagq [$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    page_xlat u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .out_valid(out_valid), .out_addr(out_addr), .out_is64(out_is64),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic check(logic ok, string tag, logic [96:0] act, logic [96:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [64:0] model(logic [31:0] a);
        logic [31:0] lo;
        logic        wide;
        lo   = m_lo[a[23:20]];
        wide = (lo[1:0] == 2'b01);
        return {wide, (wide ? m_hi[a[23:20]] : 32'h0), lo[31:20], a[19:0]};
    endfunction

    task automatic drive(logic iv, logic [31:0] ia, logic w, logic r,
                         logic [4:0] ca, logic [31:0] wd, string tag);
        @(negedge clk);
        in_valid = iv; in_addr = ia; cfg_wr = w; cfg_rd = r;
        cfg_addr = ca; cfg_wdata = wd;
        if (iv) begin
            sbq.push_back({cyc, model(ia)});
            tagq.push_back(tag);
        end
        if (w) begin
            if (ca[0]) m_hi[ca[4:1]] = wd;
            else       m_lo[ca[4:1]] = wd;
        end
    endtask

    task automatic idle();
        drive(1'b0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0, "");
    endtask

    task automatic xlat(logic [31:0] a, string tag);
        drive(1'b1, a, 1'b0, 1'b0, 5'd0, 32'h0, tag);
    endtask

    task automatic cfg_write(logic [4:0] ca, logic [31:0] wd);
        drive(1'b0, 32'h0, 1'b1, 1'b0, ca, wd, "");
    endtask

    task automatic cfg_read(logic [4:0] ca, logic [31:0] exp, string tag);
        drive(1'b0, 32'h0, 1'b0, 1'b1, ca, 32'h0, "");
        @(posedge clk); #1;
        check(cfg_rdata == exp, tag, 97'(cfg_rdata), 97'(exp));
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R2 unexpected out_valid", {33'h0, out_is64, out_addr}, 97'h0);
            end else begin
                logic [96:0] e;
                string       t;
                e = sbq.pop_front();
                t = tagq.pop_front();
                check(e[96:65] + 1 == cyc, {t, " R2 latency"}, 97'(cyc), 97'(e[96:65] + 1));
                check({out_is64, out_addr} == e[64:0], t,
                      {32'h0, out_is64, out_addr}, {32'h0, e[64:0]});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 97'h0, 97'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check(out_valid == 1'b0, "R1 out_valid after reset", 97'(out_valid), 97'h0);
        check(cfg_rdata == 32'h0, "R1 rdata after reset", 97'(cfg_rdata), 97'h0);

        // R1: zero table gives offset only, narrow.
        xlat(32'hFF3A_BCDE, "R1 zero row");
        idle();
        cfg_read(5'd7, 32'h0, "R1 row3 high after reset");

        // Program rows.
        cfg_write({4'd3, 1'b0}, 32'h1230_0001);
        cfg_write({4'd3, 1'b1}, 32'hDEAD_BEEF);
        cfg_write({4'd5, 1'b0}, 32'hABC0_0000);
        cfg_write({4'd5, 1'b1}, 32'h1111_2222);
        cfg_write({4'd7, 1'b0}, 32'h5550_0002);
        cfg_write({4'd7, 1'b1}, 32'h7777_8888);
        cfg_write({4'd8, 1'b0}, 32'h6660_0003);
        cfg_write({4'd8, 1'b1}, 32'h9999_AAAA);
        cfg_write({4'd15, 1'b0}, 32'hFFF0_0001);
        cfg_write({4'd15, 1'b1}, 32'hFFFF_FFFF);
        cfg_write({4'd0, 1'b0}, 32'h000F_FFFD);
        cfg_write({4'd0, 1'b1}, 32'h0000_0001);

        // Back-to-back translations.
        xlat(32'h0031_2345, "R5 wide row3");
        xlat(32'h5531_2345, "R4 upper bits ignored");
        xlat(32'h8053_0000, "R6 narrow row5");
        xlat(32'h0077_FFFF, "R6 reserved code 10");
        xlat(32'h0082_4680, "R6 reserved code 11");
        xlat(32'hABF0_0000, "R4 row15 select");
        xlat(32'h000F_FFFF, "R3 offset all ones");
        xlat(32'h0000_0000, "R3 offset zero");
        idle();
        idle();

        // Readback and field mapping.
        cfg_read({4'd0, 1'b0}, 32'h0000_0001, "R7 low word drops middle bits");
        cfg_read({4'd3, 1'b1}, 32'hDEAD_BEEF, "R7 high word");
        cfg_read({4'd7, 1'b0}, 32'h5550_0002, "R7 low word reserved code");
        idle();
        @(posedge clk); #1;
        check(cfg_rdata == 32'h5550_0002, "R8 hold while idle", 97'(cfg_rdata), 97'h5550_0002);
        cfg_write({4'd7, 1'b0}, 32'h1234_5678);
        @(posedge clk); #1;
        check(cfg_rdata == 32'h5550_0002, "R8 hold across write", 97'(cfg_rdata), 97'h5550_0002);
        cfg_read({4'd7, 1'b0}, 32'h1230_0000, "R8 new read after write");

        // Collision: write row5 low while translating through row5.
        drive(1'b1, 32'h0051_2345, 1'b1, 1'b0, {4'd5, 1'b0}, 32'hABC0_0001, "R9 collision old value");
        xlat(32'h0051_2345, "R9 next uses new value");
        idle();
        idle();
        idle();
        check(sbq.size() == 0, "R2 all results seen", 97'(sbq.size()), 97'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule